// File: doc/BRIEF.md
# Chained Device Select Decoder

One device in a cascade of associative-memory chips sits on a host bus that it shares with its neighbours. This block decides which host bus cycles the device acts on. There are four cycle types: command write, data write, command read and data read. It does not run any instruction and it does not drive the bus. Each host cycle arrives as a strobe, with a cycle-kind code and the decoded class of the instruction carried by the cycle. The block registers one enable for that cycle kind, and the bus and execution logic around it use that enable. A read enable is meant to drive the output-enable of the data bus tristate.

Two routing regimes decide the result. With the route input high, the device-select register chooses the device. An all-ones value broadcasts writes to every device. A value equal to the device's page address selects that one device fully. With the route input low, the device that holds the highest-priority match in the chain is selected. In enhanced mode, the other devices still take writes.

A few instruction classes override the basic decision. Some depend on the device's place in the full-flag chain, and one leaves a pending state that changes how later command reads are answered.

Top module: `cascade_sel_dec`

## Requirements
- R1: With `route_n` high and `dsel_reg` all ones, command writes and data writes are enabled and data reads are not. Command reads are not enabled unless R9 applies. The all-ones check takes precedence over the page match.
- R2: With `route_n` high and `dsel_reg` equal to `page_reg` but not all ones, all four cycle kinds are enabled.
- R3: With `route_n` high and `dsel_reg` neither all ones nor equal to `page_reg`, no cycle kind is enabled.
- R4: With `route_n` low, `mm_en` high, `match_n` low and `match_in_n` high, the device is the priority match and all four cycle kinds are enabled.
- R5: With `route_n` low and the device not the priority match, nothing is enabled in standard mode (`enh_mode`=0). In enhanced mode (`enh_mode`=1), only command writes and data writes are enabled.
- R6: A command write whose class is 1 (device-select register write) is always enabled.
- R7: A command write whose class is 2 (page-address register write) or 3 (set full flag) is enabled only when `full_in_n` is low and `full_out_n` is high.
- R8: With `mm_en` low, the match flag counts as absent, so no priority-match response (R4) can occur.
- R9: A command write of class 5 (transfer next-free address) leaves a pending state. Until the next command write, a command read is enabled only when `full_in_n` is low and `full_out_n` is high.
- R10: A command write or data write of class 4 (move to memory at next free) is enabled only when `full_in_n` is low, `full_out_n` is high, and the basic decision enables it.
- R11: In enhanced mode, a write of class 6 (move involving memory at priority match) is disabled on a device selected only through the non-priority rule of R5.
- R12: Cycle kinds are 0 command write, 1 data write, 2 command read and 3 data read. Only the enable of the strobed kind can be high, one clock after `cyc_valid` is sampled. After a clock with no strobe, and after reset, all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | Host cycle strobe |
| cyc_kind | input | 2 | Cycle kind code (R12) |
| insn_class | input | 3 | Decoded instruction class |
| dsel_reg | input | ADDR_W | Device-select register contents |
| page_reg | input | ADDR_W | Page-address register contents |
| route_n | input | 1 | High: select by register; low: select by match |
| match_n | input | 1 | Internal match flag, low when matched |
| mm_en | input | 1 | Multiple-match flag enabled in control |
| match_in_n | input | 1 | Match from higher-priority neighbours, high when none |
| full_in_n | input | 1 | Full-chain input, low when all earlier devices are full |
| full_out_n | input | 1 | Full-chain output of this device, low when full |
| enh_mode | input | 1 | 0 standard, 1 enhanced |
| en_cmd_wr | output | 1 | Command write enable |
| en_dat_wr | output | 1 | Data write enable |
| en_cmd_rd | output | 1 | Command read enable |
| en_dat_rd | output | 1 | Data read enable |

## Verification
The embedded assertions check on every cycle that at most one enable is high and that an idle cycle clears the outputs. They also check that a device-select register write is always taken, that a broadcast never drives a data read, that a page or set-full write never reaches a device outside the first-empty position, and that a disabled match flag never yields a priority read. Other behaviour depends on the whole combination of inputs and on history: the enhanced-mode write rules, the move overrides and the pending next-free read. Only the bench's sweep shows these, since it goes through every route, flag, mode, class and kind against an arithmetic model.

// File: rtl/cascade_sel_pkg.sv
// Shared codes for the chained device select decoder.
// Assumes: cycle kind and instruction class are decoded upstream.
package cascade_sel_pkg;

    typedef enum logic [1:0] {
        KIND_CMD_WR = 2'd0,
        KIND_DAT_WR = 2'd1,
        KIND_CMD_RD = 2'd2,
        KIND_DAT_RD = 2'd3
    } cyc_kind_t;

    typedef enum logic [2:0] {
        INS_PLAIN   = 3'd0,
        INS_DSEL_WR = 3'd1,
        INS_PAGE_WR = 3'd2,
        INS_SET_FULL = 3'd3,
        INS_MOV_NF  = 3'd4,
        INS_XFER_NF = 3'd5,
        INS_MOV_HP  = 3'd6,
        INS_RSVD    = 3'd7
    } insn_class_t;

    localparam int NUM_KINDS = 4;

endpackage

// File: rtl/sel_base_decode.sv
// Basic routing decision for one device in the cascade.
// Works out the write and read permission from the select registers,
// the match flags and the mode, before any instruction override.
// Assumes: all inputs are stable when the strobe is sampled.
module sel_base_decode #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] dsel_reg,
    input  logic [ADDR_W-1:0] page_reg,
    input  logic              route_n,
    input  logic              match_n,
    input  logic              mm_en,
    input  logic              match_in_n,
    input  logic              enh_mode,
    output logic              base_wr,
    output logic              base_rd,
    output logic              nonprio_enh
);

    localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};

    logic is_bcast;
    logic is_page;
    logic eff_match_n;
    logic is_prio;

    // Compare the select register against the broadcast code and page.
    always_comb begin
        is_bcast = (dsel_reg == BCAST);
        is_page  = (dsel_reg == page_reg);
    end

    // Priority match: a disabled match flag forces the match high.
    always_comb begin
        eff_match_n = match_n | ~mm_en;
        is_prio     = ~eff_match_n & match_in_n;
    end

    // Pick the write/read permission for the current routing regime.
    always_comb begin
        base_wr     = 1'b0;
        base_rd     = 1'b0;
        nonprio_enh = 1'b0;
        if (route_n) begin
            if (is_bcast) begin
                base_wr = 1'b1;
            end else if (is_page) begin
                base_wr = 1'b1;
                base_rd = 1'b1;
            end
        end else if (is_prio) begin
            base_wr = 1'b1;
            base_rd = 1'b1;
        end else if (enh_mode) begin
            base_wr     = 1'b1;
            nonprio_enh = 1'b1;
        end
    end

endmodule

// File: rtl/sel_nf_tracker.sv
// Remembers that the last command write was a transfer of the
// next-free address, so that later command reads answer from
// the first-empty device only.
// Assumes: an instruction is only carried by a command write.
module sel_nf_tracker
    import cascade_sel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_valid,
    input  cyc_kind_t   kind,
    input  insn_class_t insn,
    output logic        nf_pending
);

    // Set on a next-free transfer, cleared by any other command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nf_pending <= 1'b0;
        end else if (cyc_valid && kind == KIND_CMD_WR) begin
            nf_pending <= (insn == INS_XFER_NF);
        end
    end

endmodule

// File: rtl/sel_insn_override.sv
// Applies the instruction-class overrides to the basic decision and
// gives one decision bit per cycle kind.
// Assumes: base permissions come from sel_base_decode in this cycle.
module sel_insn_override
    import cascade_sel_pkg::*;
(
    input  insn_class_t          insn,
    input  logic                 base_wr,
    input  logic                 base_rd,
    input  logic                 nonprio_enh,
    input  logic                 full_in_n,
    input  logic                 full_out_n,
    input  logic                 nf_pending,
    output logic [NUM_KINDS-1:0] dec
);

    logic first_empty;
    logic wr_gate;

    // First empty device in the full chain.
    always_comb first_empty = ~full_in_n & full_out_n;

    // Write permission after the move overrides, shared by both writes.
    always_comb begin
        wr_gate = base_wr;
        if (insn == INS_MOV_NF && !first_empty) begin
            wr_gate = 1'b0;
        end
        if (insn == INS_MOV_HP && nonprio_enh) begin
            wr_gate = 1'b0;
        end
    end

    // Per-kind decision, including register writes and pending reads.
    always_comb begin
        dec[KIND_DAT_WR] = wr_gate;
        dec[KIND_DAT_RD] = base_rd;
        dec[KIND_CMD_RD] = nf_pending ? first_empty : base_rd;
        unique case (insn)
            INS_DSEL_WR:               dec[KIND_CMD_WR] = 1'b1;
            INS_PAGE_WR, INS_SET_FULL: dec[KIND_CMD_WR] = first_empty;
            default:                   dec[KIND_CMD_WR] = wr_gate;
        endcase
    end

endmodule

// File: rtl/cascade_sel_dec.sv
// Top of the chained device select decoder. Samples each host cycle
// strobe and registers the enable of the strobed cycle kind, valid
// one clock later. Enables clear on clocks without a strobe.
// Assumes: synchronous active-low reset; inputs meet setup on clk.
module cascade_sel_dec
    import cascade_sel_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [1:0]        cyc_kind,
    input  logic [2:0]        insn_class,
    input  logic [ADDR_W-1:0] dsel_reg,
    input  logic [ADDR_W-1:0] page_reg,
    input  logic              route_n,
    input  logic              match_n,
    input  logic              mm_en,
    input  logic              match_in_n,
    input  logic              full_in_n,
    input  logic              full_out_n,
    input  logic              enh_mode,
    output logic              en_cmd_wr,
    output logic              en_dat_wr,
    output logic              en_cmd_rd,
    output logic              en_dat_rd
);

    cyc_kind_t            kind;
    insn_class_t          insn;
    logic                 base_wr;
    logic                 base_rd;
    logic                 nonprio_enh;
    logic                 nf_pending;
    logic [NUM_KINDS-1:0] dec;
    logic [NUM_KINDS-1:0] en_q;

    // Cast the raw codes into the package types.
    always_comb begin
        kind = cyc_kind_t'(cyc_kind);
        insn = insn_class_t'(insn_class);
    end

    sel_base_decode #(.ADDR_W(ADDR_W)) base_i (
        .dsel_reg   (dsel_reg),
        .page_reg   (page_reg),
        .route_n    (route_n),
        .match_n    (match_n),
        .mm_en      (mm_en),
        .match_in_n (match_in_n),
        .enh_mode   (enh_mode),
        .base_wr    (base_wr),
        .base_rd    (base_rd),
        .nonprio_enh(nonprio_enh)
    );

    sel_nf_tracker nf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .kind      (kind),
        .insn      (insn),
        .nf_pending(nf_pending)
    );

    sel_insn_override ovr_i (
        .insn       (insn),
        .base_wr    (base_wr),
        .base_rd    (base_rd),
        .nonprio_enh(nonprio_enh),
        .full_in_n  (full_in_n),
        .full_out_n (full_out_n),
        .nf_pending (nf_pending),
        .dec        (dec)
    );

    // One enable register per cycle kind; only the strobed kind may set.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[k] <= 1'b0;
            end else begin
                en_q[k] <= cyc_valid && (cyc_kind == k[1:0]) && dec[k];
            end
        end
    end

    // Map the enable vector onto the named ports.
    always_comb begin
        en_cmd_wr = en_q[KIND_CMD_WR];
        en_dat_wr = en_q[KIND_DAT_WR];
        en_cmd_rd = en_q[KIND_CMD_RD];
        en_dat_rd = en_q[KIND_DAT_RD];
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_cmd_wr, en_dat_wr, en_cmd_rd, en_dat_rd})); // R12

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> !(en_cmd_wr | en_dat_wr | en_cmd_rd | en_dat_rd)); // R12

    AST_DSEL_WR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd0 && insn_class == 3'd1) |=> en_cmd_wr); // R6

    AST_BCAST_NO_DREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && route_n && (&dsel_reg) && cyc_kind == 2'd3) |=> !en_dat_rd); // R1

    AST_PAGE_WR_FIRST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd0 && (insn_class == 3'd2 || insn_class == 3'd3)
         && !(!full_in_n && full_out_n)) |=> !en_cmd_wr); // R7

    AST_MM_OFF_NO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !route_n && !mm_en && !enh_mode && cyc_kind == 2'd3)
        |=> !en_dat_rd); // R8

endmodule

// File: tb/cascade_sel_dec_tb_top.sv
// Sweep bench for the chained device select decoder: every routing,
// flag, mode, instruction class and cycle kind against a model.
module cascade_sel_dec_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_valid = 1'b0;
    logic [1:0]    cyc_kind = 2'd0;
    logic [2:0]    insn_class = 3'd0;
    logic [AW-1:0] dsel_reg = '0;
    logic [AW-1:0] page_reg = 16'h0012;
    logic          route_n = 1'b1;
    logic          match_n = 1'b1;
    logic          mm_en = 1'b1;
    logic          match_in_n = 1'b1;
    logic          full_in_n = 1'b1;
    logic          full_out_n = 1'b1;
    logic          enh_mode = 1'b0;
    logic          en_cmd_wr, en_dat_wr, en_cmd_rd, en_dat_rd;

    int checks = 0;
    int errors = 0;
    bit pend = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cascade_sel_dec #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .insn_class(insn_class), .dsel_reg(dsel_reg), .page_reg(page_reg),
        .route_n(route_n), .match_n(match_n), .mm_en(mm_en),
        .match_in_n(match_in_n), .full_in_n(full_in_n), .full_out_n(full_out_n),
        .enh_mode(enh_mode), .en_cmd_wr(en_cmd_wr), .en_dat_wr(en_dat_wr),
        .en_cmd_rd(en_cmd_rd), .en_dat_rd(en_dat_rd)
    );

    function automatic logic [3:0] outs();
        return {en_dat_rd, en_cmd_rd, en_dat_wr, en_cmd_wr};
    endfunction

    // Model of the requirements: returns the expected enable bit.
    function automatic bit model(output string tag);
        bit fe, prio, wr, rd, npe, e;
        fe   = !full_in_n && full_out_n;
        prio = mm_en && !match_n && match_in_n;
        npe  = 1'b0;
        if (route_n) begin
            if (&dsel_reg)                 begin wr = 1; rd = 0; tag = "R1"; end
            else if (dsel_reg == page_reg) begin wr = 1; rd = 1; tag = "R2"; end
            else                           begin wr = 0; rd = 0; tag = "R3"; end
        end else if (prio) begin
            wr = 1; rd = 1; tag = "R4";
        end else begin
            wr = enh_mode; rd = 0; npe = enh_mode;
            tag = (!mm_en && !match_n && match_in_n) ? "R8" : "R5";
        end
        if (insn_class == 3'd4 && !fe) begin wr = 0; tag = "R10"; end
        if (insn_class == 3'd6 && npe) begin wr = 0; tag = "R11"; end
        case (cyc_kind)
            2'd0: begin
                e = wr;
                if (insn_class == 3'd1) begin e = 1; tag = "R6"; end
                if (insn_class == 3'd2 || insn_class == 3'd3) begin e = fe; tag = "R7"; end
            end
            2'd1: e = wr;
            2'd2: begin
                e = rd;
                if (pend) begin e = fe; tag = "R9"; end
            end
            default: e = rd;
        endcase
        return e;
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: enables=%b expected=%b", tag, outs(), exp);
        end
    endtask

    // Present one strobed cycle, check one clock later, update model state.
    task automatic cycle_check();
        string tag;
        bit e;
        logic [3:0] exp;
        e = model(tag);
        exp = 4'b0;
        exp[cyc_kind] = e;
        cyc_valid = 1'b1;
        @(negedge clk);
        check(exp, tag);
        if (cyc_kind == 2'd0) pend = (insn_class == 3'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(4'b0, "R12 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(4'b0, "R12 idle");
        for (int sel = 0; sel < 4; sel++) begin
            dsel_reg = (sel == 0) ? '1 : (sel == 1) ? page_reg :
                       (sel == 2) ? 16'h0013 : 16'hFFFE;
            if (sel == 3) page_reg = '1;
            for (int fl = 0; fl < 128; fl++) begin
                {route_n, match_n, mm_en, match_in_n,
                 full_in_n, full_out_n, enh_mode} = fl[6:0];
                for (int ic = 0; ic < 7; ic++) begin
                    for (int k = 0; k < 4; k++) begin
                        insn_class = ic[2:0];
                        cyc_kind   = k[1:0];
                        cycle_check();
                    end
                    cyc_kind = 2'd2;
                    cycle_check();
                end
            end
            page_reg = 16'h0012;
        end
        cyc_valid = 1'b0;
        @(negedge clk);
        check(4'b0, "R12 no strobe");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule